// File: doc/BRIEF.md
# Legacy NMI Status and Control Port

This block is one byte-wide I/O port register. It collects two non-maskable interrupt sources, a system-error event and an I/O-check event. Each source has a sticky status bit, and the block raises one combined, registered NMI request from them. The same register also controls one external interval-timer channel: it drives that channel's gate, reads back the channel's output level, and passes that level to a speaker pin when the speaker data bit allows it.

Software clears a latched status bit through its control bit, which has inverted sense. Writing 1 disables the source and clears its status, and writing 0 enables the source again. The interval timer, the address decoding and any NMI masking elsewhere in the system are outside this block. Both event inputs must already be synchronous to `clk`.

Top module: `legacy_nmi_port`

## Requirements
- R1: While `rst_n` is low and after it is released, all control bits (3:0), both status bits (7, 6) and `nmi_req` are 0, so `rd_data` equals `{2'b00, tmr_out, 5'b00000}`.
- R2: A cycle with `wr_en` high stores `wr_data[3:0]` into control bits 3:0, which read back in `rd_data[3:0]` after that clock edge. Written bits 7:4 have no effect.
- R3: `rd_data[4]` always reads 0, and `rd_data[5]` always equals the live `tmr_out` level.
- R4: `sys_err_evt` high at a clock edge sets status bit 7 at that edge, provided the effective bit 2 is 0. The effective bit is `wr_data[2]` when `wr_en` is high and the stored bit 2 otherwise.
- R5: `io_chk_evt` high at a clock edge sets status bit 6 at that edge, provided the effective bit 3 is 0. The effective bit is defined the same way as in R4.
- R6: While the effective bit 2 is 1, status bit 7 is cleared and held at 0. This holds even if `sys_err_evt` is high in the same cycle that bit 2 is written to 1.
- R7: While the effective bit 3 is 1, status bit 6 is cleared and held at 0. This holds even if `io_chk_evt` is high in the same cycle that bit 3 is written to 1.
- R8: A set status bit stays set after its event input falls, until its disable bit clears it.
- R9: `nmi_req` equals the OR of status bits 7 and 6 as they were one clock earlier.
- R10: `spkr_out` is 0 when control bit 1 is 0, and equals `tmr_out` when bit 1 is 1.
- R11: `tmr_gate` equals control bit 0, so 1 enables the timer channel to count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the port |
| wr_data | input | 8 | Byte written to the port |
| rd_data | output | 8 | Current port value |
| sys_err_evt | input | 1 | System-error event, active high, synchronous |
| io_chk_evt | input | 1 | I/O-check event, active high, synchronous |
| tmr_out | input | 1 | Output level of the timer channel |
| nmi_req | output | 1 | Registered combined NMI request |
| tmr_gate | output | 1 | Count enable for the timer channel |
| spkr_out | output | 1 | Timer level gated by the speaker data bit |

## Verification
The bench runs a permuted sweep over 512 combinations of write strobe, all 16 low-nibble control values, junk or zero in the upper nibble, timer level and both event inputs. A step model checks every output after each cycle. Because the sweep covers writes both with and without concurrent events, it separates "effective disable" from "stored disable" and distinguishes sticky from level-following status. Directed sequences then cover the corner cases one at a time: a single-cycle pulse, the release of an event, the clear-by-1 then re-enable-by-0 sequence, a write of 1 together with an event, and the one-cycle lag of the NMI request.

// File: rtl/legacy_nmi_pkg.sv
// Package: shared field positions and the control-field type of the NMI port.
// Assumes an 8-bit port; bit positions are fixed by software convention.
package legacy_nmi_pkg;
    localparam int PORT_W      = 8;
    localparam int NUM_SRC     = 2;
    localparam int CTL_W       = 4;
    // Field positions inside the port byte
    localparam int IDX_SERR_ST = 7;
    localparam int IDX_IOCK_ST = 6;
    localparam int IDX_TMR_LVL = 5;
    localparam int IDX_RSVD    = 4;
    localparam int IDX_IOCK_DIS = 3;
    localparam int IDX_SERR_DIS = 2;
    localparam int IDX_SPK_EN  = 1;
    localparam int IDX_GATE_EN = 0;
    // Source numbering inside the status vector
    localparam int SRC_SERR    = 0;
    localparam int SRC_IOCK    = 1;

    typedef struct packed {
        logic iock_dis;
        logic serr_dis;
        logic spk_en;
        logic gate_en;
    } ctl_t;
endpackage

// File: rtl/nmi_ctl_reg.sv
// Module: holds the four writable control bits of the port.
// Also exposes the effective next value, so a status latch can act on the
// value being written in the same cycle. Upper written bits are dropped.
module nmi_ctl_reg
    import legacy_nmi_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output ctl_t         ctl_q,
    output ctl_t         ctl_nxt
);
    localparam int LOW_W = CTL_W;

    // Select the value the register takes at the next edge
    always_comb begin
        ctl_nxt = ctl_q;
        if (wr_en) ctl_nxt = ctl_t'(wr_data[LOW_W-1:0]);
    end

    // Store the control bits
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_nxt;
    end
endmodule

// File: rtl/nmi_src_latch.sv
// Module: one sticky NMI source status bit.
// Set by a synchronous active-high event while enabled; cleared and held at
// zero while its (inverted-sense) disable is 1. Disable wins over an event.
module nmi_src_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic dis_nxt,
    output logic st_q
);
    // Update the sticky status bit
    always_ff @(posedge clk) begin
        if (!rst_n)       st_q <= 1'b0;
        else if (dis_nxt) st_q <= 1'b0;
        else if (evt)     st_q <= 1'b1;
    end
endmodule

// File: rtl/nmi_req_reg.sv
// Module: registers the OR of all source status bits into a glitch-free
// request. Adds one cycle of latency relative to the status bits.
module nmi_req_reg #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] st,
    output logic         req_q
);
    // Register the combined request
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= |st;
    end
endmodule

// File: rtl/legacy_nmi_port.sv
// Module: top of the NMI status/control port.
// Assumes event inputs are synchronous to clk and the timer output is a
// stable level; the read value is combinational from state and tmr_out.
module legacy_nmi_port
    import legacy_nmi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PORT_W-1:0] wr_data,
    output logic [PORT_W-1:0] rd_data,
    input  logic              sys_err_evt,
    input  logic              io_chk_evt,
    input  logic              tmr_out,
    output logic              nmi_req,
    output logic              tmr_gate,
    output logic              spkr_out
);
    ctl_t               ctl_q;
    ctl_t               ctl_nxt;
    logic [NUM_SRC-1:0] evt_v;
    logic [NUM_SRC-1:0] dis_v;
    logic [NUM_SRC-1:0] st_v;

    nmi_ctl_reg #(.W(PORT_W)) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctl_q   (ctl_q),
        .ctl_nxt (ctl_nxt)
    );

    // Map each source to its event input and its effective disable
    always_comb begin
        evt_v[SRC_SERR] = sys_err_evt;
        evt_v[SRC_IOCK] = io_chk_evt;
        dis_v[SRC_SERR] = ctl_nxt.serr_dis;
        dis_v[SRC_IOCK] = ctl_nxt.iock_dis;
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        nmi_src_latch u_lat (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt     (evt_v[s]),
            .dis_nxt (dis_v[s]),
            .st_q    (st_v[s])
        );
    end

    nmi_req_reg #(.N(NUM_SRC)) u_req (
        .clk   (clk),
        .rst_n (rst_n),
        .st    (st_v),
        .req_q (nmi_req)
    );

    // Assemble the readable port byte
    always_comb begin
        rd_data               = '0;
        rd_data[IDX_SERR_ST]  = st_v[SRC_SERR];
        rd_data[IDX_IOCK_ST]  = st_v[SRC_IOCK];
        rd_data[IDX_TMR_LVL]  = tmr_out;
        rd_data[IDX_RSVD]     = 1'b0;
        rd_data[IDX_IOCK_DIS] = ctl_q.iock_dis;
        rd_data[IDX_SERR_DIS] = ctl_q.serr_dis;
        rd_data[IDX_SPK_EN]   = ctl_q.spk_en;
        rd_data[IDX_GATE_EN]  = ctl_q.gate_en;
    end

    // Drive the timer gate and the gated speaker level
    always_comb begin
        tmr_gate = ctl_q.gate_en;
        spkr_out = tmr_out & ctl_q.spk_en;
    end
endmodule

// File: rtl/legacy_nmi_port_chk.sv
// Module: port-level property checker for legacy_nmi_port, bound below.
module legacy_nmi_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       sys_err_evt,
    input logic       io_chk_evt,
    input logic       tmr_out,
    input logic       nmi_req,
    input logic       tmr_gate,
    input logic       spkr_out
);
    a_r3_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[4] == 1'b0);
    a_r3_tmr_level: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[5] == tmr_out);
    a_r4_serr_set: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_err_evt && !(wr_en ? wr_data[2] : rd_data[2])) |=> rd_data[7]);
    a_r5_iock_set: assert property (@(posedge clk) disable iff (!rst_n)
        (io_chk_evt && !(wr_en ? wr_data[3] : rd_data[3])) |=> rd_data[6]);
    a_r6_serr_held_clear: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[2] |-> !rd_data[7]);
    a_r7_iock_held_clear: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[3] |-> !rd_data[6]);
    a_r8_serr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[7] && !(wr_en && wr_data[2])) |=> rd_data[7]);
    a_r8_iock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[6] && !(wr_en && wr_data[3])) |=> rd_data[6]);
    a_r9_nmi_lag: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[7] || rd_data[6]) |=> nmi_req);
    a_r9_nmi_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[7] && !rd_data[6]) |=> !nmi_req);
    a_r10_spkr_off: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[1] |-> !spkr_out);
    a_r11_gate: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_gate == rd_data[0]);
endmodule

bind legacy_nmi_port legacy_nmi_port_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .sys_err_evt (sys_err_evt),
    .io_chk_evt  (io_chk_evt),
    .tmr_out     (tmr_out),
    .nmi_req     (nmi_req),
    .tmr_gate    (tmr_gate),
    .spkr_out    (spkr_out)
);

// File: tb/sim_legacy_nmi_port.sv
// Bench: step model plus permuted sweep and directed corner cases.
module sim_legacy_nmi_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       sys_err_evt = 1'b0;
    logic       io_chk_evt = 1'b0;
    logic       tmr_out = 1'b1;
    logic       nmi_req;
    logic       tmr_gate;
    logic       spkr_out;

    int checks = 0;
    int failures = 0;
    logic [3:0] m_ctl = '0;
    logic       m_se = 1'b0, m_ic = 1'b0, m_nmi = 1'b0;

    always #4 clk = ~clk;

    legacy_nmi_port u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .sys_err_evt(sys_err_evt), .io_chk_evt(io_chk_evt),
        .tmr_out(tmr_out), .nmi_req(nmi_req), .tmr_gate(tmr_gate),
        .spkr_out(spkr_out)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all();
        chk("R2 ctl", {4'h0, rd_data[3:0]}, {4'h0, m_ctl});
        chk("R3 rsvd", {7'h0, rd_data[4]}, 8'h0);
        chk("R3 tmr", {7'h0, rd_data[5]}, {7'h0, tmr_out});
        chk("R4/R6 serr st", {7'h0, rd_data[7]}, {7'h0, m_se});
        chk("R5/R7 iock st", {7'h0, rd_data[6]}, {7'h0, m_ic});
        chk("R9 nmi", {7'h0, nmi_req}, {7'h0, m_nmi});
        chk("R10 spkr", {7'h0, spkr_out}, {7'h0, tmr_out & m_ctl[1]});
        chk("R11 gate", {7'h0, tmr_gate}, {7'h0, m_ctl[0]});
    endtask

    // One cycle: drive at negedge, update model, compare at next negedge
    task automatic cyc(input logic wr, input logic [7:0] wd, input logic se,
                       input logic ic, input logic tm);
        logic nmi_n;
        wr_en = wr; wr_data = wd; sys_err_evt = se; io_chk_evt = ic; tmr_out = tm;
        nmi_n = m_se | m_ic;
        if (wr) m_ctl = wd[3:0];
        if (m_ctl[2]) m_se = 1'b0; else if (se) m_se = 1'b1;
        if (m_ctl[3]) m_ic = 1'b0; else if (ic) m_ic = 1'b1;
        m_nmi = nmi_n;
        @(negedge clk);
        check_all();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        chk("R1 reset rd", rd_data, 8'h20);
        chk("R1 reset nmi", {7'h0, nmi_req}, 8'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release rd", rd_data, 8'h20);
        check_all();

        // Permuted sweep over write, nibble, junk upper bits, timer, events
        for (int i = 0; i < 512; i++) begin
            int j;
            j = (i * 37) % 512;
            cyc(j[0], {j[5] ? 4'hF : 4'h0, j[4:1]}, j[7], j[8], j[6]);
        end

        // Directed: R8 single-cycle pulse stays latched
        cyc(1'b1, 8'h00, 1'b0, 1'b0, 1'b1);
        cyc(1'b1, 8'h0C, 1'b0, 1'b0, 1'b1);
        cyc(1'b1, 8'h00, 1'b0, 1'b0, 1'b1);
        cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b1);
        chk("R4 pulse sets bit7", {7'h0, rd_data[7]}, 8'h01);
        cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        chk("R9 nmi one cycle later", {7'h0, nmi_req}, 8'h01);
        repeat (3) cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
        chk("R8 sticky bit7", {7'h0, rd_data[7]}, 8'h01);
        // R6 clear with 1 then re-enable with 0
        cyc(1'b1, 8'h04, 1'b0, 1'b0, 1'b0);
        chk("R6 cleared", {7'h0, rd_data[7]}, 8'h00);
        cyc(1'b1, 8'h00, 1'b0, 1'b0, 1'b0);
        chk("R6 stays clear after re-enable", {7'h0, rd_data[7]}, 8'h00);
        // R7 same-cycle write of 1 with event does not set
        cyc(1'b1, 8'h08, 1'b0, 1'b1, 1'b0);
        chk("R7 same-cycle disable wins", {7'h0, rd_data[6]}, 8'h00);
        cyc(1'b1, 8'h00, 1'b0, 1'b1, 1'b0);
        chk("R5 set on re-enable cycle", {7'h0, rd_data[6]}, 8'h01);
        // R2 junk upper bits ignored
        cyc(1'b1, 8'hF3, 1'b0, 1'b0, 1'b1);
        chk("R2 upper bits ignored", rd_data, 8'h63);
        chk("R10 spkr follows timer", {7'h0, spkr_out}, 8'h01);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule